// File: doc/BRIEF.md
# Magic-Sequence Watchdog Timer

This block is a watchdog counter for a chip's power-management domain. Once software enables it, it counts cycles of its clock. If the count reaches a power-of-two limit before software restarts it, the block fires a reset request. To restart the count, software writes two fixed 32-bit key words, in order, to two key registers. A key written wrongly, or written out of order, is treated as a fault in its own right and also fires the reset request.

Software sees the block through a simple 32-bit register port and can take four actions:
- program the timeout exponent and the enable bit;
- feed the two keys;
- force an immediate reset request;
- read back a 3-bit code that tells why the last request was raised.

That code survives the reset the request causes. Only the block's own hard reset clears it.

Clearing the enable bit does not stop the counter at once: the stop takes effect only when the next correct key pair completes. A dedicated input lets the rest of the chip raise a user reset through the same path.

Top module: `mseq_wdt`

## Requirements
- R1: After hard reset, the configuration word (byte offset 0x04) and the cause word (byte offset 0x08) both read 0, and `rst_req` is low.
- R2: At byte offset 0x04, bit 31 is the enable and bits [4:0] are the delay. Both read back as written, and all other bits read 0.
- R3: A configuration write that sets the enable while the counter is stopped clears the count to zero. `rst_req` then goes high for exactly one cycle, 2^(delay+1) clock edges after that write's edge. The cause reads 1 (timeout), and the count restarts, so the next pulse follows 2^(delay+1) edges later.
- R4: A valid key pair restarts the count, and the next timeout comes 2^(delay+1) edges after the second key's edge. The pair is 0xABCD1234 written to offset 0x08, followed by 0x4321DCBA written to offset 0x0C.
- R5: Three writes count as a bad-key fault: a wrong value at 0x08, a wrong value at 0x0C, or a write to 0x0C without a correct 0x08 write just before it in the key sequence. While the counter runs, a bad-key fault pulses `rst_req` on the next edge with cause 2.
- R6: While the counter is stopped, a bad-key fault raises no request and leaves the cause unchanged.
- R7: Writing the enable as 0 leaves the counter running, and it still times out. Once a valid key pair completes with the enable at 0, the counter stops and no further timeouts occur.
- R8: A write at offset 0x00 with bit 0 set pulses `rst_req` on the next edge with cause 3, whether or not the counter runs. The same write with bit 0 clear has no effect.
- R9: A one-cycle pulse on `user_rst` gives a `rst_req` pulse on the next edge with cause 4, whether or not the counter runs.
- R10: The cause code changes only together with a `rst_req` pulse and holds until the next pulse. Hard reset sets it to 0.
- R11: If the delay is lowered while the counter runs and the count is already at or above the new limit, the timeout fires on the next edge.
- R12: If a valid key pair completes on the edge where a timeout would fire, no request is raised and the count restarts from zero.
- R13: When several request sources fall on the same edge, the recorded cause follows the priority user (4) > soft (3) > bad key (2) > timeout (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| user_rst | input | 1 | User reset request pulse |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
Two functions can fall on the same edge: the timeout expiring and a key pair completing. The bench places the second key write exactly on the edge where the count reaches its limit. It then judges two things: that no request is raised on that edge, and that the next timeout arrives a full period later, counted from the key edge. A second collision pits a soft-reset write against a user-reset pulse on one edge, and the cause read back must be the user code.

// File: rtl/mseq_wdt_pkg.sv
package mseq_wdt_pkg;

  typedef enum logic [2:0] {
    CAUSE_HARD    = 3'd0,
    CAUSE_TIMEOUT = 3'd1,
    CAUSE_BADKEY  = 3'd2,
    CAUSE_SOFT    = 3'd3,
    CAUSE_USER    = 3'd4
  } cause_e;

  // word selects taken from byte offset bits [3:2]
  localparam logic [1:0] SEL_SOFT  = 2'd0;
  localparam logic [1:0] SEL_CFG   = 2'd1;
  localparam logic [1:0] SEL_KEY_A = 2'd2;
  localparam logic [1:0] SEL_KEY_B = 2'd3;

  localparam logic [31:0] KEY_A_VAL = 32'hABCD_1234;
  localparam logic [31:0] KEY_B_VAL = 32'h4321_DCBA;

  localparam int CFG_EN_BIT = 31;

endpackage

// File: rtl/mseq_wdt_key.sv
module mseq_wdt_key
  import mseq_wdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic [DATA_W-1:0] wdata,
  output logic              key_ok,
  output logic              key_bad
);

  logic armed_q, armed_d;

  always_comb begin
    armed_d = armed_q;
    key_ok  = 1'b0;
    key_bad = 1'b0;
    if (wr_a) begin
      if (wdata == KEY_A_VAL[DATA_W-1:0]) begin
        armed_d = 1'b1;
      end else begin
        armed_d = 1'b0;
        key_bad = 1'b1;
      end
    end
    if (wr_b) begin
      armed_d = 1'b0;
      if (armed_q && (wdata == KEY_B_VAL[DATA_W-1:0])) key_ok = 1'b1;
      else                                              key_bad = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             armed_q <= 1'b0;
    else if (wr_a || wr_b)  armed_q <= armed_d;
  end

endmodule

// File: rtl/mseq_wdt_count.sv
module mseq_wdt_count #(
  parameter int DELAY_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               key_ok,
  input  logic               en,
  input  logic [DELAY_W-1:0] delay,
  input  logic               clr,
  output logic               run,
  output logic               expire
);

  localparam int CNT_W = (1 << DELAY_W) + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim_m1;
  logic             run_q, run_d, upd;

  assign lim_m1 = (CNT_W'(1) << (CNT_W'(delay) + CNT_W'(1))) - CNT_W'(1);
  assign expire = run_q && (cnt_q >= lim_m1) && !key_ok && !start;
  assign run    = run_q;
  assign upd    = start || key_ok || clr || run_q;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (start) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (key_ok) begin
      run_d = en;
      cnt_d = '0;
    end else if (clr || expire) begin
      cnt_d = '0;
    end else if (run_q) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/mseq_wdt.sv
module mseq_wdt
  import mseq_wdt_pkg::*;
#(
  parameter int DELAY_W = 5,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              user_rst,
  output logic              rst_req
);

  localparam int PAD_W = DATA_W - 1 - DELAY_W;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  logic [1:0] sel;
  logic       wr_soft, wr_cfg, wr_key_a, wr_key_b;

  assign sel      = reg_addr[3:2];
  assign wr_soft  = reg_wr && (sel == SEL_SOFT);
  assign wr_cfg   = reg_wr && (sel == SEL_CFG);
  assign wr_key_a = reg_wr && (sel == SEL_KEY_A);
  assign wr_key_b = reg_wr && (sel == SEL_KEY_B);

  // configuration register
  logic               cfg_en_q, cfg_en_d;
  logic [DELAY_W-1:0] cfg_dly_q, cfg_dly_d;

  always_comb begin
    cfg_en_d  = reg_wdata[CFG_EN_BIT];
    cfg_dly_d = reg_wdata[DELAY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cfg_en_q  <= 1'b0;
      cfg_dly_q <= '0;
    end else if (wr_cfg) begin
      cfg_en_q  <= cfg_en_d;
      cfg_dly_q <= cfg_dly_d;
    end
  end

  logic key_ok, key_bad, run_q, expire, start, soft_hit, fault, clr;

  mseq_wdt_key #(.DATA_W(DATA_W)) u_key (
    .clk     (clk),
    .rst_n   (rst_ns),
    .wr_a    (wr_key_a),
    .wr_b    (wr_key_b),
    .wdata   (reg_wdata),
    .key_ok  (key_ok),
    .key_bad (key_bad)
  );

  assign start    = wr_cfg && cfg_en_d && !run_q;
  assign soft_hit = wr_soft && reg_wdata[0];
  assign fault    = key_bad && run_q;
  assign clr      = user_rst || soft_hit || fault;

  mseq_wdt_count #(.DELAY_W(DELAY_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_ns),
    .start  (start),
    .key_ok (key_ok),
    .en     (cfg_en_q),
    .delay  (cfg_dly_q),
    .clr    (clr),
    .run    (run_q),
    .expire (expire)
  );

  // request and cause record
  cause_e cause_q, cause_d;
  logic   req_d, req_q;

  always_comb begin
    req_d   = clr || expire;
    cause_d = cause_q;
    if (user_rst)      cause_d = CAUSE_USER;
    else if (soft_hit) cause_d = CAUSE_SOFT;
    else if (fault)    cause_d = CAUSE_BADKEY;
    else if (expire)   cause_d = CAUSE_TIMEOUT;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) req_q <= 1'b0;
    else         req_q <= req_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)    cause_q <= CAUSE_HARD;
    else if (req_d) cause_q <= cause_d;
  end

  assign rst_req = req_q;

  always_comb begin
    unique case (sel)
      SEL_CFG:   reg_rdata = {cfg_en_q, PAD_W'(0), cfg_dly_q};
      SEL_KEY_A: reg_rdata = DATA_W'(cause_q);
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mseq_wdt_chk.sv
module mseq_wdt_chk
  import mseq_wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              user_rst,
  input logic              rst_req,
  input logic [2:0]        cause_q,
  input logic              run_q
);

  a_r9_user_req: assert property (@(posedge clk) disable iff (!rst_ns)
    user_rst |=> (rst_req && cause_q == 3'd4));

  a_r8_soft_req: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_wr && reg_addr[3:2] == SEL_SOFT && reg_wdata[0] && !user_rst)
      |=> (rst_req && cause_q == 3'd3));

  a_r5_bad_second_key: assert property (@(posedge clk) disable iff (!rst_ns)
    (run_q && reg_wr && reg_addr[3:2] == SEL_KEY_B &&
     reg_wdata != KEY_B_VAL && !user_rst)
      |=> (rst_req && cause_q == 3'd2));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_ns)
    (!run_q && !user_rst && !(reg_wr && reg_addr[3:2] == SEL_SOFT && reg_wdata[0]))
      |=> !rst_req);

  a_r10_cause_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    !rst_req |-> $stable(cause_q));

  a_r10_req_has_cause: assert property (@(posedge clk) disable iff (!rst_ns)
    rst_req |-> (cause_q != 3'd0));

endmodule

bind mseq_wdt mseq_wdt_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .user_rst  (user_rst),
  .rst_req   (rst_req),
  .cause_q   (cause_q),
  .run_q     (run_q)
);

// File: tb/sim_mseq_wdt.sv
`timescale 1ns/1ps
module sim_mseq_wdt;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        user_rst;
  logic        rst_req;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] KA = 32'hABCD_1234;
  localparam logic [31:0] KB = 32'h4321_DCBA;

  mseq_wdt u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .user_rst(user_rst),
    .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic hard_reset();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  // request must stay low for n-1 edges and be high after the n-th
  task automatic expect_pulse(input int n, input string req);
    logic early;
    early = 1'b0;
    for (int i = 1; i < n; i++) begin
      step();
      if (rst_req) early = 1'b1;
    end
    step();
    chk({31'b0, early}, 32'd0, {req, " early request"});
    chk({31'b0, rst_req}, 32'd1, {req, " request at limit"});
  endtask

  task automatic expect_quiet(input int n, input string req);
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      step();
      if (rst_req) seen = 1'b1;
    end
    chk({31'b0, seen}, 32'd0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; user_rst = 1'b0;
    hard_reset();

    // R1
    chk({31'b0, rst_req}, 32'd0, "R1 rst_req");
    rd(4'h4, d); chk(d, 32'd0, "R1 config");
    rd(4'h8, d); chk(d, 32'd0, "R1 cause");

    // R2
    wr(4'h4, 32'h7FFF_FFF5);
    rd(4'h4, d); chk(d, 32'h0000_0015, "R2 delay readback");
    rd(4'h0, d); chk(d, 32'd0, "R2 other offset reads zero");
    hard_reset();

    // R3 sweep over delays, two periods each
    for (int dl = 0; dl < 7; dl++) begin
      hard_reset();
      wr(4'h4, 32'h8000_0000 | dl);
      rd(4'h4, d); chk(d, 32'h8000_0000 | dl, "R2 enable readback");
      expect_pulse(1 << (dl + 1), "R3 first timeout");
      rd(4'h8, d); chk(d, 32'd1, "R3 cause timeout");
      expect_pulse(1 << (dl + 1), "R3 second timeout");
    end

    // R4 key pair restarts count
    hard_reset();
    wr(4'h4, 32'h8000_0004);
    expect_quiet(20, "R4 before key");
    wr(4'h8, KA);
    wr(4'hC, KB);
    chk({31'b0, rst_req}, 32'd0, "R4 no request on key");
    expect_pulse(32, "R4 timeout after key");

    // R5 bad keys while running
    hard_reset();
    wr(4'h4, 32'h8000_0005);
    wr(4'h8, 32'h1234_5678);
    chk({31'b0, rst_req}, 32'd1, "R5 wrong first key");
    rd(4'h8, d); chk(d, 32'd2, "R5 cause bad key");
    step();
    wr(4'hC, KB);
    chk({31'b0, rst_req}, 32'd1, "R5 second key unarmed");
    step();
    wr(4'h8, KA);
    chk({31'b0, rst_req}, 32'd0, "R5 correct first key");
    wr(4'hC, 32'h0);
    chk({31'b0, rst_req}, 32'd1, "R5 wrong second key");

    // R6 bad key while stopped
    hard_reset();
    wr(4'h8, 32'hDEAD_BEEF);
    chk({31'b0, rst_req}, 32'd0, "R6 no request");
    rd(4'h8, d); chk(d, 32'd0, "R6 cause unchanged");

    // R7 deferred disable
    hard_reset();
    wr(4'h4, 32'h8000_0003);
    wr(4'h4, 32'h0000_0003);
    expect_pulse(15, "R7 still running after disable");
    wr(4'h8, KA);
    wr(4'hC, KB);
    expect_quiet(100, "R7 stopped after key pair");

    // R8 soft reset
    wr(4'h0, 32'h0);
    chk({31'b0, rst_req}, 32'd0, "R8 bit0 clear ignored");
    wr(4'h0, 32'h1);
    chk({31'b0, rst_req}, 32'd1, "R8 soft request");
    rd(4'h8, d); chk(d, 32'd3, "R8 cause soft");

    // R9 user reset
    user_rst = 1'b1; step(); user_rst = 1'b0;
    chk({31'b0, rst_req}, 32'd1, "R9 user request");
    rd(4'h8, d); chk(d, 32'd4, "R9 cause user");
    step();
    chk({31'b0, rst_req}, 32'd0, "R9 pulse width");

    // R10 cause held, cleared by hard reset only
    repeat (50) step();
    rd(4'h8, d); chk(d, 32'd4, "R10 cause held");
    hard_reset();
    rd(4'h8, d); chk(d, 32'd0, "R10 cleared by hard reset");

    // R11 delay lowered below count
    wr(4'h4, 32'h8000_0006);
    expect_quiet(40, "R11 before change");
    wr(4'h4, 32'h8000_0002);
    expect_pulse(1, "R11 immediate expiry");
    rd(4'h8, d); chk(d, 32'd1, "R11 cause timeout");

    // R12 key pair on expiry edge
    hard_reset();
    wr(4'h4, 32'h8000_0003);
    expect_quiet(14, "R12 before key");
    wr(4'h8, KA);
    wr(4'hC, KB);
    chk({31'b0, rst_req}, 32'd0, "R12 key wins over expiry");
    expect_pulse(16, "R12 restart after key");

    // R13 soft and user on one edge
    hard_reset();
    user_rst = 1'b1;
    wr(4'h0, 32'h1);
    user_rst = 1'b0;
    chk({31'b0, rst_req}, 32'd1, "R13 request");
    rd(4'h8, d); chk(d, 32'd4, "R13 user over soft");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule